// File: doc/BRIEF.md
# Clock Calendar with Hundredths Counter

This block keeps wall-clock time and a calendar from a 32.768 kHz clock enable, `src_en`, sampled on a faster system clock. A fractional prescaler turns that enable into exactly one hundredths-of-a-second step per 327.68 enables on average. It does this by spacing the steps 327 or 328 enables apart. The step drives a chain of BCD counters: hundredths, seconds, minutes, hours, day of week, date, month and a two-digit year. Year 00 counts as 2000, and the calendar stays correct through 2099.

Software loads every field at once through a 64-bit write port. Each field is one BCD byte. From the least significant byte up, the order is: hundredths, seconds, minutes, hours, day of week, date, month, year. The read port returns the same layout. It is taken as a snapshot in a single clock, so a carry that ripples through several fields can never be seen half-applied.

A two-bit selector routes one of these onto `freq_out`: a 1 Hz wave, a 100 Hz wave, or the raw source rate.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields hold year 00, month 01, date 01, day of week 00 and a time of 00:00:00.00, and `freq_out` is low.
- R2: After a write, the first hundredths step follows the 328th `src_en` pulse. Exactly 100 steps follow every 32768 pulses, so 32767 pulses after a write leave hundredths at 99 and one more pulse reaches the next second.
- R3: A write stores `wr_time` into all fields, one BCD byte per field: bits 7:0 hundredths, 15:8 seconds, 23:16 minutes, 31:24 hours, 39:32 day of week, 47:40 date, 55:48 month, 63:56 year. The write clears the prescaler and discards any `src_en` pulse in the same cycle.
- R4: A read request raises `rd_valid` on the next cycle. At that point `rd_time` holds every field as it stood in the request cycle, and it stays unchanged until the next request.
- R5: Hundredths wrap 99 to 00, seconds and minutes wrap 59 to 00, and hours wrap 23 to 00, each passing a carry upward. Midnight advances the date.
- R6: Day of week runs 00 to 06 and wraps to 00. April, June, September and November end at 30, and the other months except February end at 31.
- R7: February ends at 29 when the year value is a multiple of 4, including 00. In every other year it ends at 28.
- R8: Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R9: With `fsel` = 00, `freq_out` stays low.
- R10: With `fsel` = 01, `freq_out` is high while hundredths is 00–49 and low while it is 50–99, one cycle behind the counter.
- R11: With `fsel` = 10, `freq_out` is a square wave that the write clears low, making 100 rising edges per 32768 `src_en` pulses.
- R12: With `fsel` = 11, `freq_out` equals `src_en` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 1 | One-cycle pulse per 32.768 kHz source period |
| wr_en | input | 1 | Load all fields from `wr_time` |
| wr_time | input | 64 | Packed BCD fields to load |
| rd_req | input | 1 | Capture a snapshot of all fields |
| rd_valid | output | 1 | Snapshot captured on the previous cycle |
| rd_time | output | 64 | Snapshot of all fields, same layout as `wr_time` |
| fsel | input | 2 | Frequency output select |
| freq_out | output | 1 | Selected frequency output |

## Verification
A software write and a source enable pulse can land on the same clock, and the write has to win. If the stray pulse were counted, the prescaler phase would be off by one. The bench makes every write with `src_en` held high in that cycle. It then gives 32767 further pulses and expects hundredths still at 99, then one more pulse and expects the next second at hundredths 00. An off-by-one in either direction shows up as a mismatch in the scoreboard.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int FIELD_W  = 8;
   localparam int N_FIELDS = 8;
   localparam int TIME_W   = FIELD_W * N_FIELDS;

   typedef struct packed {
      logic [FIELD_W-1:0] year;
      logic [FIELD_W-1:0] month;
      logic [FIELD_W-1:0] date;
      logic [FIELD_W-1:0] dow;
      logic [FIELD_W-1:0] hour;
      logic [FIELD_W-1:0] minute;
      logic [FIELD_W-1:0] sec;
      logic [FIELD_W-1:0] hund;
   } rtc_time_t;

   localparam rtc_time_t RESET_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                        dow: 8'h00, hour: 8'h00, minute: 8'h00,
                                        sec: 8'h00, hund: 8'h00};

   // add one to a two-digit BCD value
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [3:0] hi;
      logic [3:0] lo;
      hi = v[7:4];
      lo = v[3:0];
      if (lo == 4'd9) begin
         hi = hi + 4'd1;
         lo = 4'd0;
      end else begin
         lo = lo + 4'd1;
      end
      return {hi, lo};
   endfunction

   function automatic logic is_leap(input logic [7:0] yr);
      logic [6:0] ybin;
      ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
      return (ybin[1:0] == 2'b00);
   endfunction

   // final date of a month, in BCD
   function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int SRC_HZ  = 32768,
   parameter int TICK_HZ = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_en,
   input  logic clear,
   output logic half_tick,
   output logic hund_tick
);
   localparam int STEP  = 2 * TICK_HZ;
   localparam int ACC_W = $clog2(SRC_HZ + STEP);

   if (SRC_HZ <= STEP) begin : g_ratio_bad
      $error("rtc_prescaler: SRC_HZ must exceed twice TICK_HZ");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic             wrap;
   logic             phase_q;

   always_comb begin
      acc_sum = acc_q + ACC_W'(STEP);
      wrap    = (acc_sum >= ACC_W'(SRC_HZ));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         acc_q     <= '0;
         phase_q   <= 1'b0;
         half_tick <= 1'b0;
         hund_tick <= 1'b0;
      end else begin
         half_tick <= 1'b0;
         hund_tick <= 1'b0;
         if (src_en) begin
            if (wrap) begin
               acc_q     <= acc_sum - ACC_W'(SRC_HZ);
               half_tick <= 1'b1;
               phase_q   <= ~phase_q;
               hund_tick <= phase_q;
            end else begin
               acc_q <= acc_sum;
            end
         end
      end
   end

   // R2
   hund_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hund_tick |=> !hund_tick);
   // R2
   half_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick |=> !half_tick);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t now_q
);
   localparam logic [7:0] HUND_LAST = 8'h99;
   localparam logic [7:0] SIX_LAST  = 8'h59;
   localparam logic [7:0] HOUR_LAST = 8'h23;
   localparam logic [7:0] DOW_LAST  = 8'h06;
   localparam logic [7:0] MON_LAST  = 8'h12;
   localparam logic [7:0] YEAR_LAST = 8'h99;

   rtc_time_t nxt;
   logic      carry;

   always_comb begin
      nxt   = now_q;
      carry = 1'b1;
      if (now_q.hund == HUND_LAST) nxt.hund = '0;
      else begin
         nxt.hund = bcd_inc(now_q.hund);
         carry    = 1'b0;
      end
      if (carry) begin
         if (now_q.sec == SIX_LAST) nxt.sec = '0;
         else begin
            nxt.sec = bcd_inc(now_q.sec);
            carry   = 1'b0;
         end
      end
      if (carry) begin
         if (now_q.minute == SIX_LAST) nxt.minute = '0;
         else begin
            nxt.minute = bcd_inc(now_q.minute);
            carry      = 1'b0;
         end
      end
      if (carry) begin
         if (now_q.hour == HOUR_LAST) nxt.hour = '0;
         else begin
            nxt.hour = bcd_inc(now_q.hour);
            carry    = 1'b0;
         end
      end
      if (carry) begin
         nxt.dow = (now_q.dow == DOW_LAST) ? 8'h00 : bcd_inc(now_q.dow);
         if (now_q.date == month_end(now_q.month, now_q.year)) nxt.date = 8'h01;
         else begin
            nxt.date = bcd_inc(now_q.date);
            carry    = 1'b0;
         end
      end
      if (carry) begin
         if (now_q.month == MON_LAST) nxt.month = 8'h01;
         else begin
            nxt.month = bcd_inc(now_q.month);
            carry     = 1'b0;
         end
      end
      if (carry) begin
         nxt.year = (now_q.year == YEAR_LAST) ? 8'h00 : bcd_inc(now_q.year);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     now_q <= RESET_TIME;
      else if (load)  now_q <= load_val;
      else if (step)  now_q <= nxt;
   end

   logic day_end;
   assign day_end = (now_q.hour == HOUR_LAST) && (now_q.minute == SIX_LAST) &&
                    (now_q.sec == SIX_LAST) && (now_q.hund == HUND_LAST);

   // R3
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (now_q == $past(load_val)));
   // R5
   midnight_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && day_end) |=> (now_q.hour == 8'h00 && now_q.hund == 8'h00));
   // R7
   leap_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && day_end && now_q.month == 8'h02 && now_q.date == 8'h28 &&
       is_leap(now_q.year)) |=> (now_q.date == 8'h29));
endmodule

// File: rtl/rtc_freq_out.sv
module rtc_freq_out (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       src_en,
   input  logic       half_tick,
   input  logic [7:0] hund,
   input  logic [1:0] fsel,
   output logic       fout
);
   localparam logic [1:0] SEL_OFF  = 2'b00;
   localparam logic [1:0] SEL_1HZ  = 2'b01;
   localparam logic [1:0] SEL_100  = 2'b10;
   localparam logic [7:0] HALF_SEC = 8'h50;

   logic sq100_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) sq100_q <= 1'b0;
      else if (half_tick)  sq100_q <= ~sq100_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fout <= 1'b0;
      else begin
         case (fsel)
            SEL_OFF: fout <= 1'b0;
            SEL_1HZ: fout <= (hund < HALF_SEC);
            SEL_100: fout <= sq100_q;
            default: fout <= src_en;
         endcase
      end
   end

   // R9
   fout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel == SEL_OFF) |=> !fout);
   // R12
   fout_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel == 2'b11) |=> (fout == $past(src_en)));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int SRC_HZ = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_en,
   input  logic              wr_en,
   input  logic [TIME_W-1:0] wr_time,
   input  logic              rd_req,
   output logic              rd_valid,
   output logic [TIME_W-1:0] rd_time,
   input  logic [1:0]        fsel,
   output logic              freq_out
);
   localparam int TICK_HZ = 100;

   if (SRC_HZ < 2 * TICK_HZ + 1) begin : g_src_bad
      $error("rtc_calendar: source rate too low for hundredths");
   end

   logic              half_tick;
   logic              hund_tick;
   rtc_time_t         cur;
   logic [TIME_W-1:0] cur_flat;

   rtc_prescaler #(.SRC_HZ(SRC_HZ), .TICK_HZ(TICK_HZ)) u_pre (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .clear(wr_en),
      .half_tick(half_tick), .hund_tick(hund_tick)
   );

   rtc_calendar_core u_core (
      .clk(clk), .rst_n(rst_n), .step(hund_tick), .load(wr_en),
      .load_val(rtc_time_t'(wr_time)), .now_q(cur)
   );

   rtc_freq_out u_fout (
      .clk(clk), .rst_n(rst_n), .clear(wr_en), .src_en(src_en),
      .half_tick(half_tick), .hund(cur.hund), .fsel(fsel), .fout(freq_out)
   );

   assign cur_flat = cur;

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_shadow
      always_ff @(posedge clk) begin
         if (!rst_n)      rd_time[i*FIELD_W +: FIELD_W] <= '0;
         else if (rd_req) rd_time[i*FIELD_W +: FIELD_W] <= cur_flat[i*FIELD_W +: FIELD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_req;
   end

   // R4
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   // R4
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_time));
endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_time = '0;
   logic        rd_req = 1'b0;
   logic        rd_valid;
   logic [63:0] rd_time;
   logic [1:0]  fsel = 2'b00;
   logic        freq_out;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic [63:0] val;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #4 clk = ~clk;

   rtc_calendar u_dut (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_en(wr_en), .wr_time(wr_time),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_time(rd_time),
      .fsel(fsel), .freq_out(freq_out)
   );

   function automatic logic [63:0] mk(input logic [7:0] y, mo, d, w, h, mi, s, c);
      return {y, mo, d, w, h, mi, s, c};
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // monitor: pops one expected item for each snapshot the design returns
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb_q.size() == 0) check("R4 unexpected rd_valid", 64'd1, 64'd0);
         else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, rd_time, it.val);
         end
      end
   end

   // every write collides with a source pulse (R3 discard)
   task automatic write_time(input logic [63:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_time = v; src_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; src_en = 1'b0;
   endtask

   task automatic feed(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         src_en = 1'b1;
      end
      @(negedge clk);
      src_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic expect_read(input logic [63:0] v, input string tag);
      item_t it;
      it.val = v; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      @(negedge clk);
   endtask

   int rises;
   logic prev_fo;

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 freq_out after reset", {63'd0, freq_out}, 64'd0);
      expect_read(mk(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), "R1 reset fields");

      // R2 R5 R6 R8: new year's eve through midnight
      write_time(mk(8'h23, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59, 8'h99));
      feed(327);
      expect_read(mk(8'h23, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59, 8'h99), "R2 no step before 328");
      feed(1);
      expect_read(mk(8'h24, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), "R8 year rollover");

      // R4 snapshot holds while time moves
      feed(500);
      check("R4 snapshot held", rd_time, mk(8'h24, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00));

      // R7 leap years
      write_time(mk(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99));
      feed(328);
      expect_read(mk(8'h24, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00), "R7 leap year 24");
      write_time(mk(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
      feed(328);
      expect_read(mk(8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00), "R7 common year 23");
      write_time(mk(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99));
      feed(328);
      expect_read(mk(8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00), "R7 year 00 leap");

      // R8 century wrap
      write_time(mk(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59, 8'h99));
      feed(328);
      expect_read(mk(8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00), "R8 year 99 wrap");

      // R6 month lengths and weekday wrap
      write_time(mk(8'h25, 8'h04, 8'h30, 8'h06, 8'h23, 8'h59, 8'h59, 8'h99));
      feed(328);
      expect_read(mk(8'h25, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), "R6 april end, dow wrap");
      write_time(mk(8'h25, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
      feed(328);
      expect_read(mk(8'h25, 8'h02, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00), "R6 january end");
      write_time(mk(8'h25, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
      feed(328);
      expect_read(mk(8'h25, 8'h01, 8'h31, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00), "R6 day 31 exists");

      // R5 partial carries
      write_time(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h10, 8'h59, 8'h59, 8'h99));
      feed(328);
      expect_read(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h11, 8'h00, 8'h00, 8'h00), "R5 hour carry");
      write_time(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h34, 8'h09, 8'h19));
      feed(328);
      expect_read(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h34, 8'h09, 8'h20), "R5 bcd digit carry");

      // R2 R3 exact second, write cycle pulse discarded
      write_time(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h00, 8'h00, 8'h00));
      feed(32767);
      expect_read(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h00, 8'h00, 8'h99), "R3 one short of second");
      feed(1);
      expect_read(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h00, 8'h01, 8'h00), "R2 exact second");

      // R9 output off
      fsel = 2'b00;
      rises = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         src_en = i[0];
         if (freq_out) rises++;
      end
      src_en = 1'b0;
      check("R9 off stays low", 64'(rises), 64'd0);

      // R10 one hertz level
      fsel = 2'b01;
      write_time(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h00, 8'h00, 8'h30));
      repeat (2) @(negedge clk);
      check("R10 first half high", {63'd0, freq_out}, 64'd1);
      write_time(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h00, 8'h00, 8'h70));
      repeat (2) @(negedge clk);
      check("R10 second half low", {63'd0, freq_out}, 64'd0);
      write_time(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h00, 8'h00, 8'h49));
      feed(328);
      check("R10 edge at 50", {63'd0, freq_out}, 64'd0);

      // R11 hundred hertz square
      fsel = 2'b10;
      write_time(mk(8'h25, 8'h06, 8'h15, 8'h01, 8'h12, 8'h00, 8'h00, 8'h00));
      rises = 0;
      prev_fo = freq_out;
      for (int i = 0; i < 32768; i++) begin
         @(negedge clk);
         src_en = 1'b1;
         if (freq_out && !prev_fo) rises++;
         prev_fo = freq_out;
      end
      @(negedge clk);
      src_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (freq_out && !prev_fo) rises++;
         prev_fo = freq_out;
         @(negedge clk);
      end
      check("R11 rising edges per second", 64'(rises), 64'd100);
      check("R11 ends low", {63'd0, freq_out}, 64'd0);

      // R12 source rate passthrough
      fsel = 2'b11;
      @(negedge clk);
      rises = 0;
      for (int i = 0; i < 64; i++) begin
         logic v;
         v = ((i % 3) == 0);
         src_en = v;
         @(negedge clk);
         if (freq_out !== v) rises++;
      end
      src_en = 1'b0;
      check("R12 delayed source", 64'(rises), 64'd0);

      repeat (4) @(negedge clk);
      check("R4 all reads returned", 64'(sb_q.size()), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule